// File: doc/BRIEF.md
# Integer Multiply-Accumulate Execution Unit

This unit performs one operation from a group of eight integer multiply instructions. A 3-bit operation code selects the operation. The short forms give a 32-bit result. They can also add the product to a 32-bit accumulator, or subtract the product from it. The long forms give a full 64-bit product, signed or unsigned. They can also add a 64-bit accumulator built from a high/low word pair. One further unsigned long form adds both accumulator words to the product as two separate 32-bit addends.

The surrounding pipeline drives a one-cycle start strobe. With it, the pipeline presents the opcode, the set-flags bit, the two multiplicands and the accumulator words. One clock later the unit presents the low and high result words, qualified by a done pulse. Alongside them it gives per-word write-enables, the N and Z flags with their update enable, and an undefined-operation indication.

Register file access, condition evaluation and fetch stay outside this unit.

Top module: `mac_exec_unit`

## Requirements
- R1: After reset, `done`, `wr_lo`, `wr_hi`, `nz_upd`, `cv_upd` and `undef_op` are all 0.
- R2: A `start` strobe sampled on a rising edge produces `done` = 1 for exactly one cycle, starting at that edge. Without `start`, `done`, the write-enables, `nz_upd` and `undef_op` are 0.
- R3: Opcode 0 returns the low 32 bits of `mul_a*mul_b` in `res_lo`. It drives `res_hi` = 0 and asserts `wr_lo` only, not `wr_hi`.
- R4: Opcode 1 returns `acc_lo + mul_a*mul_b`. Opcode 3 returns `acc_lo - mul_a*mul_b`. Both keep only 32 bits and are short forms: `wr_lo` only, `res_hi` = 0.
- R5: Opcode 4 returns the unsigned 64-bit product and opcode 6 the signed 64-bit product. The low word goes to `res_lo`, the high word to `res_hi`, and both `wr_lo` and `wr_hi` are asserted.
- R6: Opcode 5 (unsigned) and opcode 7 (signed) return `{acc_hi,acc_lo}` plus the 64-bit product, modulo 2^64, as a long result.
- R7: Opcode 2 returns the unsigned product plus zero-extended `acc_lo` plus zero-extended `acc_hi` as a long result. It never asserts `nz_upd`.
- R8: When `set_flags` = 1 and the operation is defined, `nz_upd` = 1. N is bit 63 of the result for long forms and bit 31 for short forms. Z is 1 only when all result bits of that form are 0. When `set_flags` = 0, `nz_upd` = 0.
- R9: Opcode 2 with `set_flags` = 1 raises `undef_op` with `done`. In that case `wr_lo`, `wr_hi` and `nz_upd` stay 0.
- R10: `cv_upd` is 0 for every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation strobe |
| op | input | 3 | Operation code (0..7) |
| set_flags | input | 1 | Request N/Z flag update |
| mul_a | input | W | First multiplicand |
| mul_b | input | W | Second multiplicand |
| acc_lo | input | W | Short accumulator / low accumulator word |
| acc_hi | input | W | High accumulator word |
| done | output | 1 | Result valid pulse |
| res_lo | output | W | Low result word |
| res_hi | output | W | High result word (0 for short forms) |
| wr_lo | output | 1 | Low word write-enable |
| wr_hi | output | 1 | High word write-enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| nz_upd | output | 1 | N/Z update enable |
| cv_upd | output | 1 | C/V update enable, always 0 |
| undef_op | output | 1 | Undefined operation indication |

## Verification
The assertions check the following on every cycle:
- `done` only follows a `start`.
- Write-enables and the flag update appear only with `done`.
- A high-word write always comes with a low-word write.
- An undefined operation never writes.
- For long results, Z agrees with both result words being zero.

The arithmetic of each opcode can only be shown by the bench's scenarios. These compare results against independently computed 64-bit references. They cover the carry and wrap corners (all-ones operands, signed minus-one products, accumulator overflow past 2^64, exact-zero subtract results) and the flag choice between bit 31 and bit 63.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [2:0] {
        OP_MUL     = 3'd0,
        OP_MULADD  = 3'd1,
        OP_DUALADD = 3'd2,
        OP_MULSUB  = 3'd3,
        OP_UMUL64  = 3'd4,
        OP_UMAC64  = 3'd5,
        OP_SMUL64  = 3'd6,
        OP_SMAC64  = 3'd7
    } mac_op_e;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_ADD,
        ACC_SUB,
        ACC_DUAL
    } acc_mode_e;

    typedef struct packed {
        logic      is_long;
        logic      is_signed;
        acc_mode_e acc;
        logic      undef;
        logic      set_nz;
    } mac_ctrl_t;

    function automatic mac_ctrl_t decode_op(mac_op_e op, logic s);
        mac_ctrl_t c;
        c.is_long   = 1'b0;
        c.is_signed = 1'b0;
        c.acc       = ACC_NONE;
        c.undef     = 1'b0;
        c.set_nz    = s;
        unique case (op)
            OP_MUL:     c.acc = ACC_NONE;
            OP_MULADD:  c.acc = ACC_ADD;
            OP_MULSUB:  c.acc = ACC_SUB;
            OP_DUALADD: begin
                c.is_long = 1'b1;
                c.acc     = ACC_DUAL;
                c.set_nz  = 1'b0;
                c.undef   = s;
            end
            OP_UMUL64:  c.is_long = 1'b1;
            OP_UMAC64:  begin c.is_long = 1'b1; c.acc = ACC_ADD; end
            OP_SMUL64:  begin c.is_long = 1'b1; c.is_signed = 1'b1; end
            OP_SMAC64:  begin c.is_long = 1'b1; c.is_signed = 1'b1; c.acc = ACC_ADD; end
            default:    c.undef = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mac_decode.sv
module mac_decode
    import mac_pkg::*;
(
    input  logic [2:0] op,
    input  logic       set_flags,
    output mac_ctrl_t  ctrl
);
    always_comb begin
        ctrl = decode_op(mac_op_e'(op), set_flags);
    end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
    import mac_pkg::*;
#(
    parameter int W = 32
) (
    input  mac_ctrl_t          ctrl,
    input  logic [W-1:0]       mul_a,
    input  logic [W-1:0]       mul_b,
    input  logic [W-1:0]       acc_lo,
    input  logic [W-1:0]       acc_hi,
    output logic [2*W-1:0]     result,
    output logic               neg,
    output logic               zero
);
    localparam int DW = 2 * W;

    logic [W:0]           ext_a, ext_b;
    logic signed [DW+1:0] prod_full;
    logic [DW-1:0]        prod;
    logic [DW-1:0]        lo_ext, hi_ext, acc_pair;
    logic [DW-1:0]        sum;

    always_comb begin
        // one extra bit lets a single signed multiplier serve both signednesses
        ext_a     = {ctrl.is_signed & mul_a[W-1], mul_a};
        ext_b     = {ctrl.is_signed & mul_b[W-1], mul_b};
        prod_full = $signed(ext_a) * $signed(ext_b);
        prod      = prod_full[DW-1:0];
        lo_ext    = {{W{1'b0}}, acc_lo};
        hi_ext    = {{W{1'b0}}, acc_hi};
        acc_pair  = {acc_hi, acc_lo};

        unique case (ctrl.acc)
            ACC_NONE: sum = prod;
            ACC_ADD:  sum = prod + (ctrl.is_long ? acc_pair : lo_ext);
            ACC_SUB:  sum = lo_ext - prod;
            ACC_DUAL: sum = prod + lo_ext + hi_ext;
            default:  sum = prod;
        endcase

        result = sum;
        if (!ctrl.is_long) begin
            result[DW-1:W] = '0;
        end
        neg  = ctrl.is_long ? result[DW-1] : result[W-1];
        zero = (result == '0);
    end
endmodule

// File: rtl/mac_exec_unit.sv
module mac_exec_unit
    import mac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic         set_flags,
    input  logic [W-1:0] mul_a,
    input  logic [W-1:0] mul_b,
    input  logic [W-1:0] acc_lo,
    input  logic [W-1:0] acc_hi,
    output logic         done,
    output logic [W-1:0] res_lo,
    output logic [W-1:0] res_hi,
    output logic         wr_lo,
    output logic         wr_hi,
    output logic         flag_n,
    output logic         flag_z,
    output logic         nz_upd,
    output logic         cv_upd,
    output logic         undef_op
);
    localparam int DW = 2 * W;

    mac_ctrl_t     ctrl;
    logic [DW-1:0] result;
    logic          neg, zero;

    mac_decode u_decode (
        .op        (op),
        .set_flags (set_flags),
        .ctrl      (ctrl)
    );

    mac_datapath #(.W(W)) u_datapath (
        .ctrl   (ctrl),
        .mul_a  (mul_a),
        .mul_b  (mul_b),
        .acc_lo (acc_lo),
        .acc_hi (acc_hi),
        .result (result),
        .neg    (neg),
        .zero   (zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            res_lo   <= '0;
            res_hi   <= '0;
            wr_lo    <= 1'b0;
            wr_hi    <= 1'b0;
            flag_n   <= 1'b0;
            flag_z   <= 1'b0;
            nz_upd   <= 1'b0;
            undef_op <= 1'b0;
        end else begin
            done     <= start;
            wr_lo    <= start & ~ctrl.undef;
            wr_hi    <= start & ~ctrl.undef & ctrl.is_long;
            nz_upd   <= start & ~ctrl.undef & ctrl.set_nz;
            undef_op <= start & ctrl.undef;
            if (start) begin
                res_lo <= result[W-1:0];
                res_hi <= result[DW-1:W];
                flag_n <= neg;
                flag_z <= zero;
            end
        end
    end

    // multiply operations never touch carry or overflow
    assign cv_upd = 1'b0;

    // R2
    done_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start));
    // R2
    enables_need_done_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_lo || wr_hi || nz_upd || undef_op) |-> done);
    // R5
    hi_write_pairs_lo_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hi |-> wr_lo);
    // R9
    undef_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        undef_op |-> (!wr_lo && !wr_hi && !nz_upd));
    // R8
    long_zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (nz_upd && wr_hi) |-> (flag_z == ((res_lo == '0) && (res_hi == '0))));
    // R8
    long_neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (nz_upd && wr_hi) |-> (flag_n == res_hi[W-1]));

endmodule

// File: tb/test_mac_exec_unit.sv
`timescale 1ns/1ps
module test_mac_exec_unit;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [2:0]   op;
    logic         set_flags;
    logic [W-1:0] mul_a, mul_b, acc_lo, acc_hi;
    logic         done, wr_lo, wr_hi, flag_n, flag_z, nz_upd, cv_upd, undef_op;
    logic [W-1:0] res_lo, res_hi;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    mac_exec_unit #(.W(W)) i_mac_exec_unit (
        .clk(clk), .rst(rst), .start(start), .op(op), .set_flags(set_flags),
        .mul_a(mul_a), .mul_b(mul_b), .acc_lo(acc_lo), .acc_hi(acc_hi),
        .done(done), .res_lo(res_lo), .res_hi(res_hi), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .flag_n(flag_n), .flag_z(flag_z), .nz_upd(nz_upd), .cv_upd(cv_upd),
        .undef_op(undef_op)
    );

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: run did not finish (actual hang, expected completion)");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'd0: return "R3";
            3'd1, 3'd3: return "R4";
            3'd4, 3'd6: return "R5";
            3'd5, 3'd7: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [63:0] ref_result(input logic [2:0] o, input logic [31:0] a,
            input logic [31:0] b, input logic [31:0] lo, input logic [31:0] hi);
        logic [63:0] ua, ub, sa, sb, r;
        ua = {32'd0, a};
        ub = {32'd0, b};
        sa = {{32{a[31]}}, a};
        sb = {{32{b[31]}}, b};
        case (o)
            3'd0: r = {32'd0, 32'((ua * ub))};
            3'd1: r = {32'd0, 32'((ua * ub) + {32'd0, lo})};
            3'd3: r = {32'd0, 32'({32'd0, lo} - (ua * ub))};
            3'd4: r = ua * ub;
            3'd6: r = sa * sb;
            3'd5: r = ua * ub + {hi, lo};
            3'd7: r = sa * sb + {hi, lo};
            default: r = ua * ub + {32'd0, lo} + {32'd0, hi};
        endcase
        return r;
    endfunction

    task automatic apply(input logic [2:0] o, input logic s, input logic [31:0] a,
            input logic [31:0] b, input logic [31:0] lo, input logic [31:0] hi);
        logic [63:0] r;
        logic is_long, undef_e, nz_e, n_e, z_e, wlo_e, whi_e;
        r       = ref_result(o, a, b, lo, hi);
        is_long = o[2] || (o == 3'd2);
        undef_e = s && (o == 3'd2);
        nz_e    = s && (o != 3'd2);
        wlo_e   = !undef_e;
        whi_e   = !undef_e && is_long;
        n_e     = is_long ? r[63] : r[31];
        z_e     = (r == 64'd0);

        @(negedge clk);
        start = 1'b1; op = o; set_flags = s;
        mul_a = a; mul_b = b; acc_lo = lo; acc_hi = hi;
        @(negedge clk);
        start = 1'b0;
        op = 3'($urandom); mul_a = $urandom; mul_b = $urandom;

        checks++;
        if (!done || wr_lo !== wlo_e || wr_hi !== whi_e || undef_op !== undef_e) begin
            fails++;
            $display("FAIL %s/R9 op=%0d s=%0d ctl act done=%b wl=%b wh=%b ud=%b exp 1 %b %b %b",
                req_of(o), o, s, done, wr_lo, wr_hi, undef_op, wlo_e, whi_e, undef_e);
        end
        if (!undef_e) begin
            checks++;
            if ({res_hi, res_lo} !== r) begin
                fails++;
                $display("FAIL %s op=%0d a=%h b=%h lo=%h hi=%h act %h exp %h",
                    req_of(o), o, a, b, lo, hi, {res_hi, res_lo}, r);
            end
        end
        checks++;
        if (nz_upd !== nz_e || (nz_e && (flag_n !== n_e || flag_z !== z_e))) begin
            fails++;
            $display("FAIL R8 op=%0d s=%0d act upd=%b n=%b z=%b exp upd=%b n=%b z=%b",
                o, s, nz_upd, flag_n, flag_z, nz_e, n_e, z_e);
        end
        checks++;
        if (cv_upd !== 1'b0) begin
            fails++;
            $display("FAIL R10 op=%0d act cv_upd=%b exp 0", o, cv_upd);
        end
        @(negedge clk);
        checks++;
        if (done || wr_lo || wr_hi || nz_upd || undef_op) begin
            fails++;
            $display("FAIL R2 idle cycle act done=%b wl=%b wh=%b nz=%b ud=%b exp 0 0 0 0 0",
                done, wr_lo, wr_hi, nz_upd, undef_op);
        end
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        rst = 1'b1; start = 1'b0; op = '0; set_flags = 1'b0;
        mul_a = '0; mul_b = '0; acc_lo = '0; acc_hi = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (done || wr_lo || wr_hi || nz_upd || cv_upd || undef_op) begin
            fails++;
            $display("FAIL R1 reset act done=%b wl=%b wh=%b nz=%b cv=%b ud=%b exp all 0",
                done, wr_lo, wr_hi, nz_upd, cv_upd, undef_op);
        end

        // directed corners
        apply(3'd0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0);
        apply(3'd0, 1'b1, 32'h0001_0000, 32'h0001_0000, 32'h0, 32'h0);   // short zero
        apply(3'd1, 1'b1, 32'h0000_0002, 32'h4000_0000, 32'h1, 32'h5);
        apply(3'd3, 1'b1, 32'h0000_0007, 32'h0000_0003, 32'd21, 32'h9);  // exact zero
        apply(3'd3, 1'b1, 32'h0000_0001, 32'h0000_0001, 32'd0, 32'h0);   // wraps negative
        apply(3'd4, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0);
        apply(3'd6, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0);
        apply(3'd6, 1'b1, 32'h8000_0000, 32'h0000_0001, 32'h0, 32'h0);
        apply(3'd5, 1'b1, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply(3'd7, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 32'h0);
        apply(3'd7, 1'b1, 32'h0000_0000, 32'h1234_5678, 32'h0, 32'h8000_0000);
        apply(3'd2, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply(3'd2, 1'b1, 32'h0000_0003, 32'h0000_0005, 32'h1, 32'h2);   // undefined
        apply(3'd4, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0, 32'h0);

        // random
        for (int i = 0; i < 400; i++) begin
            logic [2:0] ro;
            logic [31:0] ra, rb;
            ro = 3'($urandom);
            ra = $urandom;
            rb = $urandom;
            if (($urandom % 8) == 0) ra = 32'hFFFF_FFFF;
            if (($urandom % 8) == 0) rb = 32'h8000_0000;
            apply(ro, 1'($urandom), ra, rb, $urandom, $urandom);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule